// File: doc/BRIEF.md
# Transport Stream Output Formatter

The block sits between a byte-producing decoder and a transport stream output port. Decoded bytes come in on a valid/ready stream and go into an internal FIFO. The FIFO holds at least one whole packet, so a packet on the output never has a gap inside it. Once a full packet of 188 bytes is stored, the block sends it out without a break. It forces the first byte of every packet to the sync value 0x47. In parallel format it drives one byte per clock. In serial format it drives one bit per clock, most significant bit first, on the lowest data line.

Three strobes go with the data: sync, valid and error. Each strobe has its own polarity bit. While the upstream chain reports that it is still acquiring the channel, the error strobe is held active, the valid strobe stays inactive and no packet starts. A packet that upstream has marked uncorrectable carries an active error strobe for its whole length. The output clock is the core clock passed straight through, so reset never stops or disturbs it.

Input back-pressure follows a simple rule. `in_ready` is high whenever the FIFO has a free entry. A byte is taken on every rising edge where both `in_valid` and `in_ready` are high. The upstream side holds `in_data` and `in_err` steady until that happens. Nothing is ever dropped.

Top module: `ts_out_fmt`

## Requirements
- R1: `ts_clk` equals `clk` at all times, including while `rst_n` is low.
- R2: Every output packet is exactly 188 bytes. Its first byte is 0x47, replacing the first byte of each group of 188 accepted input bytes. The remaining 187 bytes are the following input bytes, in order of acceptance.
- R3: In parallel format (`ser_mode`=0) a packet occupies 188 consecutive clocks, one byte per clock on `ts_data`. The valid strobe is active on every one of those clocks, and the sync strobe is active only on the first clock.
- R4: In serial format (`ser_mode`=1) each byte takes 8 consecutive clocks, bit 7 first, on `ts_data[0]`, with `ts_data[7:1]`=0. A packet is 1504 consecutive clocks with the valid strobe active throughout, and the sync strobe is active only on the first bit of the first byte.
- R5: A packet starts only when the FIFO holds at least 188 bytes and `acq` is low. Otherwise the valid strobe stays inactive between packets.
- R6: While no packet is being sent, the error strobe is active exactly when `acq` is high. While `acq` is high no new packet starts.
- R7: The error strobe is active on every clock of a packet whose first input byte was accepted with `in_err`=1, and inactive on every clock of any other packet. `in_err` on the other 187 bytes is ignored.
- R8: `pol_sync`, `pol_val` and `pol_err` set to 1 make the matching strobe pin active-low; set to 0 it is active-high.
- R9: `in_ready` is low exactly when the FIFO holds `FIFO_DEPTH` bytes. No accepted byte is lost.
- R10: During and right after reset the valid and sync strobes are inactive, `ts_data` is 0 and `in_ready` is high.
- R11: `ser_mode` is taken at the start of each packet. Changing it during a packet has no effect until the next packet.
- R12: `ts_data` is 0 on every clock where the valid strobe is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the output byte/bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | FIFO can take a byte |
| in_data | input | 8 | Decoded byte |
| in_err | input | 1 | Uncorrectable mark, meaningful on a packet's first byte |
| acq | input | 1 | Channel acquisition in progress |
| ser_mode | input | 1 | 0 parallel, 1 serial output |
| pol_sync | input | 1 | 1 inverts the sync strobe |
| pol_val | input | 1 | 1 inverts the valid strobe |
| pol_err | input | 1 | 1 inverts the error strobe |
| ts_clk | output | 1 | Continuous output clock |
| ts_data | output | 8 | Output byte, or serial bit on bit 0 |
| ts_sync | output | 1 | Packet start strobe |
| ts_val | output | 1 | Data valid strobe |
| ts_err | output | 1 | Error / acquisition strobe |

## Verification
The assertions assume that the polarity bits change only while no packet is on the port. A flip at any other time would look like a strobe edge, for example a false packet start. They also assume that the upstream side never asserts `in_valid` with data it might withdraw, so the FIFO count moves only on real transfers. The bench changes polarity only after the expected-data queue has drained and the valid strobe is inactive. It drives every input just after a rising edge, and it holds each offered byte until `in_ready` lets it through. One deliberate exception is `ser_mode`, which the bench changes in the middle of a packet to exercise R11.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int unsigned TS_BYTE_W = 8;
  localparam logic [TS_BYTE_W-1:0] TS_SYNC = 8'h47;

  typedef struct packed {
    logic                 err;
    logic [TS_BYTE_W-1:0] data;
  } ts_entry_t;

  localparam int unsigned TS_ENTRY_W = $bits(ts_entry_t);
endpackage

// File: rtl/ts_fifo.sv
module ts_fifo #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic [CW-1:0] count
);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok;

  assign full    = (count == CNT_FULL);
  assign push_ok = push && !full;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)     rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ts_lane.sv
module ts_lane #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned BIT_W = $clog2(BYTE_W)
) (
  input  logic              ser,
  input  logic [BYTE_W-1:0] cur,
  input  logic [BIT_W-1:0]  bit_idx,
  output logic [BYTE_W-1:0] q
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  always_comb begin
    q = cur;
    if (ser) begin
      q    = '0;
      q[0] = cur[BIT_LAST - bit_idx];
    end
  end
endmodule

// File: rtl/ts_pol.sv
module ts_pol #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] act,
  input  logic [N-1:0] pol,
  output logic [N-1:0] pin
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    assign pin[g] = act[g] ^ pol[g];
  end
endmodule

// File: rtl/ts_framer.sv
module ts_framer
  import ts_pkg::*;
#(
  parameter int unsigned PKT_LEN = 188,
  localparam int unsigned CNT_W  = $clog2(PKT_LEN),
  localparam int unsigned BIT_W  = $clog2(TS_BYTE_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pkt_ready,
  input  ts_entry_t            head,
  input  logic                 acq,
  input  logic                 ser_mode,
  output logic                 pop,
  output logic                 mode_o,
  output logic [TS_BYTE_W-1:0] data_o,
  output logic                 sync_o,
  output logic                 val_o,
  output logic                 err_o
);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(PKT_LEN - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(TS_BYTE_W - 1);

  logic                 busy, mode_q, perr_q;
  logic [CNT_W-1:0]     byte_idx;
  logic [BIT_W-1:0]     bit_idx;
  logic [TS_BYTE_W-1:0] cur;
  logic                 byte_end, pkt_end, start;

  assign byte_end = busy && (!mode_q || bit_idx == BIT_LAST);
  assign pkt_end  = byte_end && (byte_idx == BYTE_LAST);
  assign start    = pkt_ready && !acq && (!busy || pkt_end);
  assign pop      = start || (byte_end && !pkt_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      mode_q   <= 1'b0;
      perr_q   <= 1'b0;
      byte_idx <= '0;
      bit_idx  <= '0;
      cur      <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      mode_q   <= ser_mode;
      perr_q   <= head.err;
      byte_idx <= '0;
      bit_idx  <= '0;
      cur      <= TS_SYNC;
    end else if (pkt_end) begin
      busy     <= 1'b0;
      perr_q   <= 1'b0;
      bit_idx  <= '0;
      cur      <= '0;
    end else if (byte_end) begin
      byte_idx <= byte_idx + 1'b1;
      bit_idx  <= '0;
      cur      <= head.data;
    end else if (busy) begin
      bit_idx  <= bit_idx + 1'b1;
    end
  end

  ts_lane #(.BYTE_W(TS_BYTE_W)) u_lane (
    .ser     (mode_q),
    .cur     (cur),
    .bit_idx (bit_idx),
    .q       (data_o)
  );

  assign mode_o = mode_q;
  assign val_o  = busy;
  assign sync_o = busy && (byte_idx == '0) && (bit_idx == '0);
  assign err_o  = busy ? perr_q : acq;
endmodule

// File: rtl/ts_out_fmt.sv
module ts_out_fmt
  import ts_pkg::*;
#(
  parameter int unsigned PKT_LEN    = 188,
  parameter int unsigned FIFO_DEPTH = 256,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [TS_BYTE_W-1:0] in_data,
  input  logic                 in_err,
  input  logic                 acq,
  input  logic                 ser_mode,
  input  logic                 pol_sync,
  input  logic                 pol_val,
  input  logic                 pol_err,
  output logic                 ts_clk,
  output logic [TS_BYTE_W-1:0] ts_data,
  output logic                 ts_sync,
  output logic                 ts_val,
  output logic                 ts_err
);
  ts_entry_t   wr_entry, head;
  logic        fifo_full, pop, frm_mode;
  logic [CW-1:0] fifo_count;
  logic        sync_a, val_a, err_a;
  logic        pkt_ready;

  assign ts_clk   = clk;
  assign wr_entry = '{err: in_err, data: in_data};
  assign in_ready = !fifo_full;
  assign pkt_ready = (fifo_count >= CW'(PKT_LEN));

  ts_fifo #(.W(TS_ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (in_valid),
    .din   (wr_entry),
    .pop   (pop),
    .dout  (head),
    .full  (fifo_full),
    .count (fifo_count)
  );

  ts_framer #(.PKT_LEN(PKT_LEN)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_ready (pkt_ready),
    .head      (head),
    .acq       (acq),
    .ser_mode  (ser_mode),
    .pop       (pop),
    .mode_o    (frm_mode),
    .data_o    (ts_data),
    .sync_o    (sync_a),
    .val_o     (val_a),
    .err_o     (err_a)
  );

  ts_pol #(.N(3)) u_pol (
    .act ({sync_a, val_a, err_a}),
    .pol ({pol_sync, pol_val, pol_err}),
    .pin ({ts_sync, ts_val, ts_err})
  );
endmodule

// File: rtl/ts_out_fmt_chk.sv
module ts_out_fmt_chk
  import ts_pkg::*;
#(
  parameter int unsigned PKT_LEN    = 188,
  parameter int unsigned FIFO_DEPTH = 256,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_ready,
  input logic                 acq,
  input logic                 pol_sync,
  input logic                 pol_val,
  input logic                 pol_err,
  input logic [TS_BYTE_W-1:0] ts_data,
  input logic                 ts_sync,
  input logic                 ts_val,
  input logic                 ts_err,
  input logic                 frm_mode,
  input logic [CW-1:0]        fifo_count
);
  logic sync_act, val_act, err_act;
  assign sync_act = ts_sync ^ pol_sync;
  assign val_act  = ts_val ^ pol_val;
  assign err_act  = ts_err ^ pol_err;

  assert_sync_in_pkt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_act |-> val_act);

  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !val_act |-> (ts_data == '0));

  assert_sync_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_act && !frm_mode) |-> (ts_data == TS_SYNC));

  assert_serial_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_act && frm_mode) |=> (val_act && ts_data == TS_BYTE_W'(TS_SYNC[TS_BYTE_W-2])));

  assert_start_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(val_act) |-> ($past(fifo_count) >= CW'(PKT_LEN)));

  assert_acq_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acq && !val_act) |-> err_act);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count <= CW'(FIFO_DEPTH)) && ((fifo_count == CW'(FIFO_DEPTH)) == !in_ready));
endmodule

bind ts_out_fmt ts_out_fmt_chk #(.PKT_LEN(PKT_LEN), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .acq        (acq),
  .pol_sync   (pol_sync),
  .pol_val    (pol_val),
  .pol_err    (pol_err),
  .ts_data    (ts_data),
  .ts_sync    (ts_sync),
  .ts_val     (ts_val),
  .ts_err     (ts_err),
  .frm_mode   (frm_mode),
  .fifo_count (fifo_count)
);

// File: tb/test_ts_out_fmt.sv
`timescale 1ns/100ps
module test_ts_out_fmt;
  import ts_pkg::*;
  localparam int PKT = 188;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_err = 1'b0, acq = 1'b0, ser_mode = 1'b0;
  logic pol_sync = 1'b0, pol_val = 1'b0, pol_err = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, ts_clk, ts_sync, ts_val, ts_err;
  logic [7:0] ts_data;

  int n_tests = 0, n_fail = 0, act_cycles = 0;
  int pos = 0, bitn = 0;
  bit mmode = 1'b0, done = 1'b0;
  logic [7:0] sh = '0;
  ts_entry_t q[$];

  always #2.5 clk = ~clk;

  ts_out_fmt i_ts_out_fmt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_err(in_err), .acq(acq), .ser_mode(ser_mode),
    .pol_sync(pol_sync), .pol_val(pol_val), .pol_err(pol_err),
    .ts_clk(ts_clk), .ts_data(ts_data), .ts_sync(ts_sync),
    .ts_val(ts_val), .ts_err(ts_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Driver: offers one packet, pushes expected output bytes onto the scoreboard.
  task automatic push_pkt(input bit perr, input int pause_at);
    for (int i = 0; i < PKT; i++) begin
      ts_entry_t ex;
      logic [7:0] b;
      if (i == pause_at) begin
        in_valid = 1'b0;
        repeat (30) tick();
        chk((ts_val ^ pol_val) == 1'b0, "R5 no start below full packet", ts_val, pol_val);
      end
      b = 8'($urandom);
      ex.data = (i == 0) ? TS_SYNC : b;
      ex.err  = perr;
      q.push_back(ex);
      in_data  = b;
      in_err   = (i == 0) ? perr : (i == 5);
      in_valid = 1'b1;
      forever begin
        @(negedge clk);
        if (in_ready) begin tick(); break; end
        tick();
      end
      if ($urandom_range(3) == 0) begin in_valid = 1'b0; tick(); end
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) tick();
    repeat (4) tick();
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic v, s, e;
      v = ts_val ^ pol_val; s = ts_sync ^ pol_sync; e = ts_err ^ pol_err;
      if (v) begin
        act_cycles++;
        if (pos == 0 && bitn == 0) mmode = ser_mode;
        chk(s == (pos == 0 && bitn == 0), mmode ? "R4 sync position" : "R3 sync position", s, pos);
        if (q.size() == 0) chk(1'b0, "R2 unexpected byte", ts_data, -1);
        else begin
          chk(e == q[0].err, "R7 error strobe", e, q[0].err);
          if (!mmode) begin
            chk(ts_data == q[0].data, "R2 parallel byte", ts_data, q[0].data);
            void'(q.pop_front()); pos++;
          end else begin
            chk(ts_data[7:1] == 7'd0, "R4 upper lines zero", ts_data, 0);
            sh = {sh[6:0], ts_data[0]};
            if (bitn == 7) begin
              chk(sh == q[0].data, "R4 serial byte", sh, q[0].data);
              void'(q.pop_front()); pos++; bitn = 0;
            end else bitn++;
          end
          if (pos == PKT) pos = 0;
        end
      end else begin
        chk(pos == 0 && bitn == 0, mmode ? "R4 gap in packet" : "R3 gap in packet", pos, 0);
        chk(ts_data == 8'd0, "R12 idle data", ts_data, 0);
        chk(e == acq, "R6 idle error strobe", e, acq);
      end
    end
  end

  initial begin
    repeat (3) begin
      @(posedge clk); #1;
      chk(ts_clk === clk, "R1 clock in reset", ts_clk, clk);
      @(negedge clk); #1;
      chk(ts_clk === clk, "R1 clock in reset", ts_clk, clk);
    end
    chk(ts_val == 1'b0 && ts_sync == 1'b0, "R10 strobes in reset", {ts_val, ts_sync}, 0);
    chk(ts_data == 8'd0, "R10 data in reset", ts_data, 0);
    rst_n = 1'b1;
    tick();
    chk(in_ready == 1'b1, "R10 ready after reset", in_ready, 1);
    chk(ts_val == 1'b0, "R10 valid after reset", ts_val, 0);

    // Parallel: start waits for a full packet
    push_pkt(1'b0, 187);
    drain();
    // Parallel back to back, one flagged packet
    fork
      begin push_pkt(1'b1, -1); push_pkt(1'b0, -1); end
    join
    drain();

    // Serial packets
    ser_mode = 1'b1;
    tick();
    push_pkt(1'b0, -1);
    drain();
    // R11: flip mode mid-packet; packet must still take 1504 clocks
    act_cycles = 0;
    fork
      push_pkt(1'b1, -1);
      begin
        while ((ts_val ^ pol_val) == 1'b0) tick();
        repeat (50) tick();
        ser_mode = 1'b0;
      end
    join
    drain();
    chk(act_cycles == PKT * 8, "R11 mode held for packet", act_cycles, PKT * 8);

    // R8: inverted strobes
    pol_sync = 1'b1; pol_val = 1'b1; pol_err = 1'b1;
    tick();
    chk(ts_val == 1'b1 && ts_sync == 1'b1 && ts_err == 1'b1, "R8 inverted idle levels",
        {ts_sync, ts_val, ts_err}, 7);
    push_pkt(1'b1, -1);
    drain();
    pol_sync = 1'b0; pol_val = 1'b0; pol_err = 1'b0;
    tick();

    // R6/R9: acquisition holds output while FIFO fills
    acq = 1'b1;
    tick();
    chk(ts_err == 1'b1 && ts_val == 1'b0, "R6 acquisition strobes", {ts_err, ts_val}, 2);
    fork
      begin push_pkt(1'b0, -1); push_pkt(1'b1, -1); end
      begin
        repeat (500) tick();
        chk(in_ready == 1'b0, "R9 ready low when full", in_ready, 0);
        chk(ts_val == 1'b0, "R6 no start during acquisition", ts_val, 0);
        chk(ts_err == 1'b1, "R6 error during acquisition", ts_err, 1);
        acq = 1'b0;
      end
    join
    drain();
    chk(q.size() == 0, "R9 no byte lost", q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule